// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from internal sources into a sticky pending-status word and from it produces one interrupt request. The request is modelled as a drive-low enable for an active-low, open-drain line. The block pulls the line low only when it drives the enable, and leaves it floating otherwise. Software services the interrupt by reading the status word through a small register port. That single read returns every pending bit and clears them all at once.

The request passes two gates. A per-bit mask selects which pending bits may raise it. A global enable bit can hold it off entirely while events keep accumulating, so servicing can be deferred.

A two-state request machine has the states `ST_QUIET` (line released) and `ST_PULLING` (line pulled low). The transition `QUIET -> PULLING` is taken when the enable is 1 and any bit of (status AND mask) is set. The transition `PULLING -> QUIET` is taken when that condition no longer holds. In every other case the machine stays in its current state.

Top module: `irq_gate_ctrl`

## Requirements
- R1: An event bit `evt_i[k]` that is 1 in a cycle sets pending bit k. The bit stays set until a status read, and any number of bits may be pending together.
- R2: A read with `rd_en_i`=1 and `addr_i`=0 (status) returns the pending word on `rdata_o` in the cycle after the read strobe.
- R3: A status read clears every pending bit, including bits whose events arrived before the read.
- R4: An event that arrives in the same cycle as a status read is kept. It is pending after the read, and it is not part of the returned word.
- R5: With the enable at 1, `irq_pull_low_o` goes to 1 one cycle after any bit of (status AND mask) becomes set. It returns to 0 one cycle after no such bit remains.
- R6: With the enable at 0, `irq_pull_low_o` stays 0 while events still set pending bits.
- R7: The mask register sits at address 1. The enable sits at bit 0 of address 2 and reads back zero-extended. Both are written with `wr_en_i` and read back unchanged. Reading them does not clear the pending bits. A write to address 0 has no effect on the pending bits.
- R8: After reset, the pending bits, the mask and the enable are all 0 and `irq_pull_low_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | WIDTH | Event pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 enable |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data, valid the cycle after `rd_en_i` |
| irq_pull_low_o | output | 1 | Drive-low enable for the active-low request line |

## Verification
The assertions take for granted that `addr_i` and the strobes are stable 0/1 values at each clock edge. They also assume a read result is looked at only in the cycle right after its strobe. The bench changes every input half a cycle away from the sampling edge and never raises a read and a write in the same cycle. Because of that, the register port never sees a combined access whose outcome the requirements leave open. Events, by contrast, are freely overlapped with status reads, since R4 defines that case.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd2;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_PULLING = 1'b1
    } req_state_t;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] pend_o
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[k] <= 1'b0;
            end else if (clr_i) begin
                pend_o[k] <= evt_i[k];
            end else begin
                pend_o[k] <= pend_o[k] | evt_i[k];
            end
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int WIDTH = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [irq_gate_pkg::ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]              wdata_i,
    output logic [WIDTH-1:0]              mask_o,
    output logic                          en_o
);
    import irq_gate_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
            en_o   <= 1'b0;
        end else if (wr_en_i) begin
            if (addr_i == ADDR_MASK) begin
                mask_o <= wdata_i;
            end
            if (addr_i == ADDR_ENABLE) begin
                en_o <= wdata_i[0];
            end
        end
    end
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    output logic pull_o
);
    import irq_gate_pkg::*;

    req_state_t state_q;
    req_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (want_i)  state_d = ST_PULLING;
            ST_PULLING: if (!want_i) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        pull_o = (state_q == ST_PULLING);
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WIDTH-1:0]                evt_i,
    input  logic                            wr_en_i,
    input  logic                            rd_en_i,
    input  logic [irq_gate_pkg::ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]                wdata_i,
    output logic [WIDTH-1:0]                rdata_o,
    output logic                            irq_pull_low_o
);
    import irq_gate_pkg::*;

    logic [WIDTH-1:0] stat_q;
    logic [WIDTH-1:0] mask_q;
    logic             en_q;
    logic             stat_clr;
    logic             want_irq;
    logic [WIDTH-1:0] rd_sel;

    assign stat_clr = rd_en_i && (addr_i == ADDR_STATUS);
    assign want_irq = en_q && (|(stat_q & mask_q));

    irq_pend_reg #(.WIDTH(WIDTH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (stat_clr),
        .pend_o (stat_q)
    );

    irq_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .mask_o  (mask_q),
        .en_o    (en_q)
    );

    irq_req_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_i (want_irq),
        .pull_o (irq_pull_low_o)
    );

    always_comb begin
        unique case (addr_i)
            ADDR_STATUS: rd_sel = stat_q;
            ADDR_MASK:   rd_sel = mask_q;
            ADDR_ENABLE: rd_sel = {{(WIDTH-1){1'b0}}, en_q};
            default:     rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= rd_sel;
        end
    end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int WIDTH = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [WIDTH-1:0]                evt_i,
    input logic                            wr_en_i,
    input logic                            rd_en_i,
    input logic [irq_gate_pkg::ADDR_W-1:0] addr_i,
    input logic [WIDTH-1:0]                rdata_o,
    input logic                            irq_pull_low_o,
    input logic [WIDTH-1:0]                stat_q,
    input logic [WIDTH-1:0]                mask_q,
    input logic                            en_q
);
    import irq_gate_pkg::*;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && addr_i == ADDR_STATUS) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R1

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R1

    AST_READ_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_STATUS) |=> (rdata_o == $past(stat_q))); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_STATUS) |=> (stat_q == $past(evt_i))); // R3

    AST_PULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (|(stat_q & mask_q))) |=> irq_pull_low_o); // R5

    AST_PULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & mask_q) == '0) |=> !irq_pull_low_o); // R5

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !irq_pull_low_o); // R6

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(mask_q) && $stable(en_q))); // R7
endmodule

bind irq_gate_ctrl irq_gate_chk #(.WIDTH(WIDTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt_i),
    .wr_en_i        (wr_en_i),
    .rd_en_i        (rd_en_i),
    .addr_i         (addr_i),
    .rdata_o        (rdata_o),
    .irq_pull_low_o (irq_pull_low_o),
    .stat_q         (stat_q),
    .mask_q         (mask_q),
    .en_q           (en_q)
);

// File: tb/sim_irq_gate_ctrl.sv
`timescale 1ns/1ps
module sim_irq_gate_ctrl;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic         wr_en_i = 1'b0;
    logic         rd_en_i = 1'b0;
    logic [1:0]   addr_i = '0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic         irq_pull_low_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_gate_ctrl #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_pull_low_o(irq_pull_low_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [W-1:0] ev, output logic [W-1:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a; evt_i = ev;
        @(negedge clk);
        rd_en_i = 1'b0; evt_i = '0;
        d = rdata_o;
    endtask

    task automatic pulse(input logic [W-1:0] ev);
        @(negedge clk);
        evt_i = ev;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        logic [W-1:0] d;
        logic [W-1:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        check("R8 pull after reset", {31'd0, irq_pull_low_o}, '0);
        rd(2'd1, '0, d); check("R8 mask reset", d, '0);
        rd(2'd2, '0, d); check("R8 enable reset", d, '0);
        rd(2'd0, '0, d); check("R8 status reset", d, '0);

        // R6 enable off: accumulate, no request
        wr(2'd1, '1);
        pulse(32'h0000_0011);
        pulse(32'h8000_0000);
        @(negedge clk);
        check("R6 no pull while disabled", {31'd0, irq_pull_low_o}, '0);
        // R7 reading mask does not clear, status write ignored
        rd(2'd1, '0, d); check("R7 mask readback", d, '1);
        wr(2'd0, '1);
        wr(2'd0, '0);
        check("R6 still no pull", {31'd0, irq_pull_low_o}, '0);
        // R5 enabling with pending masked bits raises the request one cycle later
        wr(2'd2, 32'h0000_0003);
        check("R5 pull not yet", {31'd0, irq_pull_low_o}, '0);
        @(negedge clk);
        check("R5 pull after enable", {31'd0, irq_pull_low_o}, 32'd1);
        rd(2'd2, '0, d); check("R7 enable readback bit0", d, 32'd1);
        // R1 R2 R3 R7 accumulated word
        rd(2'd0, '0, d); check("R1 R7 accumulated status", d, 32'h8000_0011);
        check("R5 pull held one cycle after clear", {31'd0, irq_pull_low_o}, 32'd1);
        @(negedge clk);
        check("R5 pull dropped after clear", {31'd0, irq_pull_low_o}, '0);
        rd(2'd0, '0, d); check("R3 status cleared", d, '0);

        // R4 event during status read survives
        pulse(32'h0000_0100);
        rd(2'd0, 32'h0000_4000, d); check("R4 read excludes same-cycle event", d, 32'h0000_0100);
        rd(2'd0, '0, d); check("R4 same-cycle event kept", d, 32'h0000_4000);
        @(negedge clk);

        // R5 sweep: one-hot mask i against one-hot event j
        for (int i = 0; i < W; i++) begin
            wr(2'd1, 32'd1 << i);
            for (int j = 0; j < W; j++) begin
                pulse(32'd1 << j);
                check("R5 pull one cycle late", {31'd0, irq_pull_low_o}, '0);
                @(negedge clk);
                check("R5 sweep pull", {31'd0, irq_pull_low_o}, {31'd0, (i == j)});
                rd(2'd0, '0, d);
                check("R2 sweep status word", d, 32'd1 << j);
                @(negedge clk);
                check("R3 sweep pull released", {31'd0, irq_pull_low_o}, '0);
            end
        end

        // R1 R3 several pending together, then full clear
        wr(2'd1, '0);
        acc = '0;
        for (int k = 0; k < W; k += 3) begin
            pulse(32'd1 << k);
            acc |= 32'd1 << k;
        end
        rd(2'd0, '0, d); check("R1 multi pending", d, acc);
        rd(2'd0, '0, d); check("R3 all cleared", d, '0);
        // R6 disable again drops request
        wr(2'd1, '1);
        pulse(32'h0000_0002);
        @(negedge clk);
        check("R5 pull with enable", {31'd0, irq_pull_low_o}, 32'd1);
        wr(2'd2, '0);
        @(negedge clk);
        check("R6 pull dropped by disable", {31'd0, irq_pull_low_o}, '0);
        rd(2'd0, '0, d); check("R6 status kept while disabled", d, 32'h0000_0002);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule